// File: doc/BRIEF.md
# Banked Interrupt State Register File

This block keeps the per-interrupt state bits of an interrupt controller: enable, pending, active and group, one bit per interrupt, packed 32 to a word. Enable, pending and active are changed through paired set and clear addresses. Writing a 1 sets or clears the matching bit, and a 0 leaves it alone, so software never has to read, modify and write the word back. The group array is written directly. Word 0 covers interrupts 0 to 31 and has its own copy for each CPU, chosen by the requesting CPU's index. All higher words are shared. The block also keeps a 2-bit trigger configuration field and a target byte for each interrupt. Target bytes of the first 32 interrupts cannot be written, and a read of one returns the requester's own one-hot CPU mask.

Accesses use a single-cycle strobe. A register kind code and a word index select the location. A read returns its data one cycle after the request. A separate combinational query port gives a neighbouring block (for example a priority selector) the decoded state of any one interrupt as seen by any one CPU.

Top module: `irq_bank_regs`

## Requirements
- R1: Interrupt n maps to word n>>5, bit n%32 of each bit array. Bit-array words at index NUM_IRQ/32 and above read as 0, and writes to them are ignored.
- R2: Word 0 of the enable, pending, active and group arrays is a separate copy for each CPU, selected by `cpu`. Words 1 and above are the same for every CPU.
- R3: For enable (kinds 0 set, 1 clear), pending (2 set, 3 clear) and active (4 set, 5 clear), a 1 bit in a set write sets the state bit and a 1 bit in a clear write clears it. Bits written as 0 are unchanged. A read from either the set kind or the clear kind returns the current word.
- R4: Set and clear writes to pending word 0 leave bits 15:0 (interrupts 0 to 15) unchanged. Bits 31:16 are written normally.
- R5: The group array (kind 6) is written directly. An interrupt whose group bit is 0 reports `q_group0` = 1.
- R6: Configuration (kind 7) word w holds interrupts 16w to 16w+15, with interrupt 16w+i in bits [2i+1:2i]. `q_level` is 1 when the upper bit of the field is 0. `q_multi` is the lower bit, which selects per-CPU (N:N) handling rather than 1:N.
- R7: Target (kind 8) word w holds interrupts 4w to 4w+3, with byte b in bits [8b+7:8b]. For interrupts below 32 the byte is read-only and reads as 1<<cpu. Bytes for interrupts 32 and above are writable.
- R8: After reset every enable, pending, active, group, configuration and writable target bit is 0.
- R9: The address is split as addr[11:8] = kind and addr[7:0] = word index. A read (`req`=1, `we`=0) raises `rvalid` for exactly the next cycle, with `rdata` valid in that cycle. Writes produce no `rvalid`.
- R10: The query port gives, combinationally, the enable, pending, active, group-0, level, N:N and target state of interrupt `q_irq` as seen by CPU `q_cpu`. For `q_irq` >= NUM_IRQ it reports all zeros, except `q_group0` = 1 and `q_level` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| cpu | input | CW | Index of the requesting CPU |
| addr | input | 12 | Kind code [11:8] and word index [7:0] |
| wdata | input | 32 | Write data |
| rvalid | output | 1 | Read data valid |
| rdata | output | 32 | Read data |
| q_cpu | input | CW | CPU whose view the query port reports |
| q_irq | input | 10 | Interrupt number to query |
| q_enable | output | 1 | Enable bit of the queried interrupt |
| q_pending | output | 1 | Pending bit of the queried interrupt |
| q_active | output | 1 | Active bit of the queried interrupt |
| q_group0 | output | 1 | Queried interrupt is in group 0 |
| q_level | output | 1 | Queried interrupt is level-sensitive |
| q_multi | output | 1 | Queried interrupt uses N:N handling |
| q_target | output | 8 | Target byte of the queried interrupt |

## Verification
A wrong bank select or a wrong word offset shows up on the first read or query that follows: another CPU's word-0 value appears, or a shared word disagrees between CPUs. A broken set/clear mask or a broken pending-mask bit changes `rdata` in the response cycle of the very next read of that word. The query port shows the same faults without delay, because it decodes the stored state combinationally in the same cycle. That is why the checks compare both paths just after each write.

// File: rtl/irq_bank_pkg.sv
`timescale 1ns/1ps
package irq_bank_pkg;

    typedef enum logic [3:0] {
        K_EN_SET = 4'd0,
        K_EN_CLR = 4'd1,
        K_PD_SET = 4'd2,
        K_PD_CLR = 4'd3,
        K_AC_SET = 4'd4,
        K_AC_CLR = 4'd5,
        K_GRP    = 4'd6,
        K_CFG    = 4'd7,
        K_TGT    = 4'd8
    } kind_e;

    typedef enum logic [1:0] {
        WM_NONE = 2'd0,
        WM_SET  = 2'd1,
        WM_CLR  = 2'd2,
        WM_PUT  = 2'd3
    } wmode_e;

endpackage

// File: rtl/irq_bit_array.sv
`timescale 1ns/1ps
module irq_bit_array
    import irq_bank_pkg::*;
#(
    parameter int          NUM_CPU   = 4,
    parameter int          NUM_WORDS = 4,
    parameter logic [31:0] BANK0_MASK = 32'hFFFF_FFFF,
    localparam int CW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int WW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int IW = WW + 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wmode_e        wmode,
    input  logic [CW-1:0] cpu,
    input  logic [WW-1:0] word,
    input  logic [31:0]   wdata,
    output logic [31:0]   rd_word,
    input  logic [CW-1:0] q_cpu,
    input  logic [IW-1:0] q_irq,
    output logic          q_bit
);

    typedef struct packed {
        logic [NUM_CPU-1:0][31:0]   bank;
        logic [NUM_WORDS-2:0][31:0] shr;
    } st_t;

    st_t st_d, st_q;
    logic [31:0] cur_word, msk, nxt_word, q_word;
    logic [WW-1:0] q_wi;

    always_comb begin
        st_d     = st_q;
        cur_word = '0;
        msk      = '1;
        if (word == '0) begin
            cur_word = st_q.bank[cpu];
            msk      = BANK0_MASK;
        end else if (int'(word) < NUM_WORDS) begin
            cur_word = st_q.shr[int'(word) - 1];
        end
        case (wmode)
            WM_SET:  nxt_word = cur_word | (wdata & msk);
            WM_CLR:  nxt_word = cur_word & ~(wdata & msk);
            WM_PUT:  nxt_word = (cur_word & ~msk) | (wdata & msk);
            default: nxt_word = cur_word;
        endcase
        if (wmode != WM_NONE && int'(word) < NUM_WORDS) begin
            if (word == '0) st_d.bank[cpu] = nxt_word;
            else            st_d.shr[int'(word) - 1] = nxt_word;
        end
        rd_word = cur_word;

        q_wi   = q_irq[IW-1:5];
        q_word = '0;
        if (q_wi == '0)                  q_word = st_q.bank[q_cpu];
        else if (int'(q_wi) < NUM_WORDS) q_word = st_q.shr[int'(q_wi) - 1];
        q_bit = q_word[q_irq[4:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/irq_cfg_store.sv
`timescale 1ns/1ps
module irq_cfg_store #(
    parameter int NUM_IRQ = 128,
    localparam int NCW = NUM_IRQ / 16,
    localparam int CWW = (NCW > 1) ? $clog2(NCW) : 1,
    localparam int IW  = $clog2(NUM_IRQ)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic [CWW-1:0] word,
    input  logic [31:0]    wdata,
    output logic [31:0]    rd_word,
    input  logic [IW-1:0]  q_irq,
    output logic [1:0]     q_cfg
);

    typedef struct packed {
        logic [NUM_IRQ-1:0][1:0] cfg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        rd_word = '0;
        for (int i = 0; i < 16; i++) begin
            if (int'(word) * 16 + i < NUM_IRQ) begin
                rd_word[2*i +: 2] = st_q.cfg[int'(word) * 16 + i];
                if (wr) st_d.cfg[int'(word) * 16 + i] = wdata[2*i +: 2];
            end
        end
        q_cfg = st_q.cfg[q_irq];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/irq_tgt_store.sv
`timescale 1ns/1ps
module irq_tgt_store #(
    parameter int NUM_IRQ = 128,
    parameter int NUM_CPU = 4,
    localparam int CW  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int NTW = NUM_IRQ / 4,
    localparam int TWW = (NTW > 1) ? $clog2(NTW) : 1,
    localparam int IW  = $clog2(NUM_IRQ),
    localparam int NST = NUM_IRQ - 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic [CW-1:0]  cpu,
    input  logic [TWW-1:0] word,
    input  logic [31:0]    wdata,
    output logic [31:0]    rd_word,
    input  logic [CW-1:0]  q_cpu,
    input  logic [IW-1:0]  q_irq,
    output logic [7:0]     q_target
);

    typedef struct packed {
        logic [NST-1:0][7:0] tgt;
    } st_t;

    st_t st_d, st_q;
    int  n, idx, qidx;

    always_comb begin
        st_d    = st_q;
        rd_word = '0;
        n       = 0;
        idx     = 0;
        for (int b = 0; b < 4; b++) begin
            n   = int'(word) * 4 + b;
            idx = (n < 32) ? 0 : n - 32;
            if (n < 32) begin
                rd_word[8*b +: 8] = 8'd1 << cpu;
            end else if (n < NUM_IRQ) begin
                rd_word[8*b +: 8] = st_q.tgt[idx];
                if (wr) st_d.tgt[idx] = wdata[8*b +: 8];
            end
        end
        qidx = (int'(q_irq) < 32) ? 0 : int'(q_irq) - 32;
        if (int'(q_irq) < 32) q_target = 8'd1 << q_cpu;
        else                  q_target = st_q.tgt[qidx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/irq_bank_regs.sv
`timescale 1ns/1ps
module irq_bank_regs
    import irq_bank_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_IRQ = 128,
    localparam int CW  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int NW  = NUM_IRQ / 32,
    localparam int WW  = (NW > 1) ? $clog2(NW) : 1,
    localparam int IW  = WW + 5,
    localparam int NCW = NUM_IRQ / 16,
    localparam int CWW = (NCW > 1) ? $clog2(NCW) : 1,
    localparam int NTW = NUM_IRQ / 4,
    localparam int TWW = (NTW > 1) ? $clog2(NTW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [CW-1:0] cpu,
    input  logic [11:0]   addr,
    input  logic [31:0]   wdata,
    output logic          rvalid,
    output logic [31:0]   rdata,
    input  logic [CW-1:0] q_cpu,
    input  logic [9:0]    q_irq,
    output logic          q_enable,
    output logic          q_pending,
    output logic          q_active,
    output logic          q_group0,
    output logic          q_level,
    output logic          q_multi,
    output logic [7:0]    q_target
);

    typedef struct packed {
        logic        rvalid;
        logic [31:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    logic [3:0]  kind;
    logic [7:0]  widx;
    logic        bit_ok, cfg_ok, tgt_ok, wr;
    logic        q_in;
    wmode_e      wm   [4];
    logic [31:0] arr_rd [4];
    logic [3:0]  arr_q;
    logic [31:0] cfg_rd, tgt_rd;
    logic [1:0]  cfg_q;
    logic [7:0]  tgt_q;

    assign kind   = addr[11:8];
    assign widx   = addr[7:0];
    assign bit_ok = int'(widx) < NW;
    assign cfg_ok = int'(widx) < NCW;
    assign tgt_ok = int'(widx) < NTW;
    assign wr     = req && we;
    assign q_in   = int'(q_irq) < NUM_IRQ;

    // Arrays 0..2 use set/clear kind pairs; array 3 (group) is written directly.
    always_comb begin
        for (int g = 0; g < 4; g++) wm[g] = WM_NONE;
        if (wr && bit_ok) begin
            for (int g = 0; g < 3; g++) begin
                if (kind == 4'(2 * g))     wm[g] = WM_SET;
                if (kind == 4'(2 * g + 1)) wm[g] = WM_CLR;
            end
            if (kind == K_GRP) wm[3] = WM_PUT;
        end
    end

    for (genvar g = 0; g < 4; g++) begin : g_arr
        localparam logic [31:0] MSK0 = (g == 1) ? 32'hFFFF_0000 : 32'hFFFF_FFFF;
        irq_bit_array #(
            .NUM_CPU   (NUM_CPU),
            .NUM_WORDS (NW),
            .BANK0_MASK(MSK0)
        ) u_arr (
            .clk    (clk),
            .rst_n  (rst_n),
            .wmode  (wm[g]),
            .cpu    (cpu),
            .word   (widx[WW-1:0]),
            .wdata  (wdata),
            .rd_word(arr_rd[g]),
            .q_cpu  (q_cpu),
            .q_irq  (q_irq[IW-1:0]),
            .q_bit  (arr_q[g])
        );
    end

    irq_cfg_store #(.NUM_IRQ(NUM_IRQ)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr && cfg_ok && kind == K_CFG),
        .word   (widx[CWW-1:0]),
        .wdata  (wdata),
        .rd_word(cfg_rd),
        .q_irq  (q_irq[IW-1:0]),
        .q_cfg  (cfg_q)
    );

    irq_tgt_store #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_tgt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr && tgt_ok && kind == K_TGT),
        .cpu     (cpu),
        .word    (widx[TWW-1:0]),
        .wdata   (wdata),
        .rd_word (tgt_rd),
        .q_cpu   (q_cpu),
        .q_irq   (q_irq[IW-1:0]),
        .q_target(tgt_q)
    );

    always_comb begin
        rd_d        = rd_q;
        rd_d.rvalid = req && !we;
        if (req && !we) begin
            rd_d.rdata = '0;
            case (kind)
                K_EN_SET, K_EN_CLR: if (bit_ok) rd_d.rdata = arr_rd[0];
                K_PD_SET, K_PD_CLR: if (bit_ok) rd_d.rdata = arr_rd[1];
                K_AC_SET, K_AC_CLR: if (bit_ok) rd_d.rdata = arr_rd[2];
                K_GRP:              if (bit_ok) rd_d.rdata = arr_rd[3];
                K_CFG:              if (cfg_ok) rd_d.rdata = cfg_rd;
                K_TGT:              if (tgt_ok) rd_d.rdata = tgt_rd;
                default:            rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rvalid    = rd_q.rvalid;
    assign rdata     = rd_q.rdata;
    assign q_enable  = q_in && arr_q[0];
    assign q_pending = q_in && arr_q[1];
    assign q_active  = q_in && arr_q[2];
    assign q_group0  = !(q_in && arr_q[3]);
    assign q_level   = !(q_in && cfg_q[1]);
    assign q_multi   = q_in && cfg_q[0];
    assign q_target  = q_in ? tgt_q : 8'd0;

endmodule

// File: rtl/irq_bank_regs_chk.sv
`timescale 1ns/1ps
module irq_bank_regs_chk #(
    parameter int NUM_CPU = 4,
    parameter int NUM_IRQ = 128,
    localparam int CW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic          we,
    input logic [CW-1:0] cpu,
    input logic [11:0]   addr,
    input logic [31:0]   wdata,
    input logic          rvalid,
    input logic [31:0]   rdata,
    input logic [CW-1:0] q_cpu,
    input logic [9:0]    q_irq,
    input logic          q_enable,
    input logic          q_pending,
    input logic          q_active,
    input logic          q_group0,
    input logic          q_level,
    input logic          q_multi,
    input logic [7:0]    q_target
);

    logic hit_word;
    assign hit_word = addr[7:0] == {3'b000, q_irq[9:5]} && int'(q_irq) < NUM_IRQ
                      && (q_irq >= 10'd32 || cpu == q_cpu);

    p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr[11:8] == 4'd0 && hit_word && wdata[q_irq[4:0]])
        |=> (!$stable(q_irq) || !$stable(q_cpu) || q_enable));

    p_en_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr[11:8] == 4'd1 && hit_word && wdata[q_irq[4:0]])
        |=> (!$stable(q_irq) || !$stable(q_cpu) || !q_enable));

    p_sgi_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && (addr[11:8] == 4'd2 || addr[11:8] == 4'd3) && addr[7:0] == 8'd0
         && q_irq < 10'd16 && cpu == q_cpu)
        |=> (!$stable(q_irq) || !$stable(q_cpu) || q_pending == $past(q_pending)));

    p_tgt_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_irq < 10'd32) |-> ($onehot0(q_target) && q_target == (8'd1 << q_cpu)));

    p_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(req && !we));

endmodule

bind irq_bank_regs irq_bank_regs_chk #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_chk (.*);

// File: tb/sim_irq_bank_regs.sv
`timescale 1ns/1ps
module sim_irq_bank_regs;

    localparam int NUM_CPU = 4;
    localparam int NUM_IRQ = 128;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0, we = 1'b0;
    logic [CW-1:0] cpu = '0;
    logic [11:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic          rvalid;
    logic [31:0]   rdata;
    logic [CW-1:0] q_cpu = '0;
    logic [9:0]    q_irq = '0;
    logic          q_enable, q_pending, q_active, q_group0, q_level, q_multi;
    logic [7:0]    q_target;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    irq_bank_regs #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u0 (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int c, input int kind, input int word, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; cpu = CW'(c);
        addr = {4'(kind), 8'(word)}; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input int c, input int kind, input int word, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req = 1'b1; we = 1'b0; cpu = CW'(c);
        addr = {4'(kind), 8'(word)};
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic qset(input int c, input int irq);
        @(negedge clk);
        q_cpu = CW'(c); q_irq = 10'(irq);
        #1;
    endtask

    // Monitor: pops expected read data in the cycle rvalid is high.
    always @(negedge clk) begin
        if (rvalid) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state
        rd(0, 0, 0, 32'h0, "R8 enable word0 after reset");
        rd(2, 2, 1, 32'h0, "R8 pending word1 after reset");
        rd(1, 7, 2, 32'h0, "R8 config word2 after reset");
        qset(0, 40);
        check("R8 q_enable reset", q_enable, 1'b0);
        check("R8 q_group0 reset", q_group0, 1'b1);
        check("R8 q_level reset", q_level, 1'b1);

        // R3 set/clear on shared enable word 1
        wr(0, 0, 1, 32'hA5A5_0F0F);
        rd(0, 0, 1, 32'hA5A5_0F0F, "R3 enable set readback");
        wr(1, 1, 1, 32'h0000_0F00);
        rd(0, 1, 1, 32'hA5A5_000F, "R3 enable clear via clear kind");
        qset(0, 33);
        check("R3 R1 q_enable irq33 (word1 bit1)", q_enable, 1'b1);
        qset(0, 37);
        check("R3 R1 q_enable irq37 (word1 bit5)", q_enable, 1'b0);

        // R2 banking
        wr(0, 0, 0, 32'h0000_00FF);
        rd(1, 0, 0, 32'h0, "R2 cpu1 word0 not touched by cpu0");
        rd(0, 0, 0, 32'h0000_00FF, "R2 cpu0 word0 own copy");
        rd(3, 0, 1, 32'hA5A5_000F, "R2 shared word1 seen by cpu3");
        qset(0, 3);
        check("R2 q_enable irq3 cpu0", q_enable, 1'b1);
        qset(1, 3);
        check("R2 q_enable irq3 cpu1", q_enable, 1'b0);

        // R4 pending mask on word 0
        wr(0, 2, 0, 32'hFFFF_FFFF);
        rd(0, 2, 0, 32'hFFFF_0000, "R4 pending set masks low 16");
        wr(0, 3, 0, 32'h0001_FFFF);
        rd(0, 3, 0, 32'hFFFE_0000, "R4 pending clear masks low 16");
        qset(0, 5);
        check("R4 q_pending irq5", q_pending, 1'b0);
        wr(2, 2, 1, 32'h0000_FFFF);
        rd(2, 2, 1, 32'h0000_FFFF, "R4 no mask on pending word1");

        // R3 active
        wr(1, 4, 2, 32'h8000_0001);
        wr(1, 5, 2, 32'h0000_0001);
        rd(1, 4, 2, 32'h8000_0000, "R3 active set then clear");
        qset(3, 95);
        check("R3 q_active irq95", q_active, 1'b1);

        // R5 group
        wr(0, 6, 1, 32'h0000_0001);
        rd(0, 6, 1, 32'h0000_0001, "R5 group readback");
        qset(0, 32);
        check("R5 q_group0 irq32 group1", q_group0, 1'b0);
        qset(0, 33);
        check("R5 q_group0 irq33 group0", q_group0, 1'b1);

        // R6 config: word2 covers irq32..47
        wr(0, 7, 2, 32'h0000_000E);
        rd(3, 7, 2, 32'h0000_000E, "R6 config readback");
        qset(0, 32);
        check("R6 irq32 edge", q_level, 1'b0);
        check("R6 irq32 1:N", q_multi, 1'b0);
        qset(0, 33);
        check("R6 irq33 edge", q_level, 1'b0);
        check("R6 irq33 N:N", q_multi, 1'b1);
        qset(0, 34);
        check("R6 irq34 level", q_level, 1'b1);

        // R7 target
        rd(2, 8, 0, 32'h0404_0404, "R7 low target bytes cpu2");
        wr(2, 8, 0, 32'hFFFF_FFFF);
        rd(1, 8, 0, 32'h0202_0202, "R7 low target write ignored cpu1");
        wr(0, 8, 8, 32'h1122_3344);
        rd(3, 8, 8, 32'h1122_3344, "R7 high target readback");
        qset(1, 34);
        check("R7 q_target irq34", q_target, 8'h22);
        qset(3, 7);
        check("R7 q_target irq7 cpu3", q_target, 8'h08);

        // R1 out-of-range word, R10 out-of-range query
        wr(0, 0, 4, 32'hFFFF_FFFF);
        rd(0, 0, 4, 32'h0, "R1 word4 reads zero");
        rd(0, 0, 1, 32'hA5A5_000F, "R1 word1 unaffected by word4 write");
        qset(0, 200);
        check("R10 out-of-range enable", q_enable, 1'b0);
        check("R10 out-of-range target", q_target, 8'h00);

        // R9 no rvalid after a write
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = {4'd0, 8'd3}; wdata = 32'h1;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        check("R9 no rvalid after write", rvalid, 1'b0);

        repeat (4) @(negedge clk);
        check("R9 all reads answered", exp_q.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule